// File: doc/BRIEF.md
# Sub-cycle Timed Output Serializer Driver

This block turns timed write commands into the parallel words that an external serializer shifts onto a pin, several bit slots per system clock. Each word holds `WORD_W` slots (8 by default). Slot 0 goes out first and slot `WORD_W-1` goes out last. A command has a strobe, a two-bit address, one data bit and a fine position. A level command makes the pin change level at the slot the fine position selects. A separate command drives the output-enable line for the pad.

A two-state machine tracks the held pin level. It has two states, `ST_LOW` and `ST_HIGH`. Each cycle it takes one of four named transitions. `TR_RISE` goes from `ST_LOW` to `ST_HIGH` on a level command with data 1. `TR_FALL` goes from `ST_HIGH` to `ST_LOW` on a level command with data 0. `TR_REPEAT` is a level command that asks for the level already held, and the state stays. `TR_HOLD` is any cycle with no level command, and the state stays. A rise emits a word whose slots from the fine position upward are 1 and whose lower slots are 0. A fall emits the complement of that word. Both `TR_HOLD` and `TR_REPEAT` emit a word with every slot at the held level.

Top module: `tso_serializer_out`

## Requirements
- R1: After reset, `word_o` is all zeros, `oe_o` is 0 and the held level is low.
- R2: A level command (address 0) at fine position N produces one word in which slots N to `WORD_W-1` carry the new level and slots 0 to N-1 keep the previous level. Slot 0 is the earliest. For example, a rise at position 3 gives 8'b1111_1000.
- R3: In every cycle after the transition word with no new level command, the word has all slots equal to the held level.
- R4: A level command sampled at clock edge k appears in `word_o` after edge k+1, and not earlier.
- R5: A command to address 1 copies its data bit to `oe_o`. The change appears after the second edge, counting the edge that samples the strobe.
- R6: A level command that requests the level already held, including a strobe held high with unchanged data, produces a word with all slots at that level.
- R7: Commands to address 2 (reserved for input sensitivity) and to address 3 change neither `word_o` nor `oe_o`.
- R8: A fall at position 0 gives an all-zero word at once. A rise at position `WORD_W-1` from low gives only the top slot set (8'b1000_0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | Command strobe, sampled each rising edge |
| addr_i | input | 2 | Command target: 0 level, 1 output enable, 2 reserved, 3 unused |
| data_i | input | 1 | Level or enable value |
| fine_i | input | FINE_W | Slot position of a level change (0 earliest) |
| word_o | output | WORD_W | Parallel word for the serializer |
| oe_o | output | 1 | Output enable for the pad |

## Verification
Both results appear after the second rising edge, where the first is the edge that samples the command. The first register captures the command and the second updates the word or the enable. The bench drives inputs and compares outputs on falling edges. Its reference model keeps one command pending for one cycle before it applies the command to the expected word and enable. Each comparison therefore checks the command issued two falling edges earlier. The check one cycle after a command confirms that nothing has moved yet, and the next check confirms the transition word. Constrained random traffic with a fixed seed follows the directed corner cases.

// File: rtl/tso_pkg.sv
package tso_pkg;

    // Command targets; the numeric codes are part of the interface contract.
    typedef enum logic [1:0] {
        CMD_LEVEL = 2'd0,
        CMD_OE    = 2'd1,
        CMD_SENSE = 2'd2,
        CMD_SPARE = 2'd3
    } cmd_tgt_t;

    // Held pin level.
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } lvl_state_t;

    // Per-cycle transition taken by the level machine.
    typedef enum logic [1:0] {
        TR_HOLD   = 2'd0,
        TR_RISE   = 2'd1,
        TR_FALL   = 2'd2,
        TR_REPEAT = 2'd3
    } lvl_trans_t;

endpackage

// File: rtl/tso_cmd_stage.sv
module tso_cmd_stage
    import tso_pkg::*;
#(
    parameter int FINE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_i,
    input  logic [1:0]        addr_i,
    input  logic              data_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic              lvl_vld_o,
    output logic              oe_vld_o,
    output logic              data_o,
    output logic [FINE_W-1:0] fine_o
);

    logic     lvl_hit;
    logic     oe_hit;
    cmd_tgt_t tgt;

    always_comb begin
        tgt     = cmd_tgt_t'(addr_i);
        lvl_hit = 1'b0;
        oe_hit  = 1'b0;
        unique case (tgt)
            CMD_LEVEL: lvl_hit = stb_i;
            CMD_OE:    oe_hit  = stb_i;
            CMD_SENSE: ;
            CMD_SPARE: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_vld_o <= 1'b0;
            oe_vld_o  <= 1'b0;
            data_o    <= 1'b0;
            fine_o    <= '0;
        end else begin
            lvl_vld_o <= lvl_hit;
            oe_vld_o  <= oe_hit;
            data_o    <= data_i;
            fine_o    <= fine_i;
        end
    end

    // Only one of the two decoded command kinds can be live.
    p_one_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lvl_vld_o && oe_vld_o));

endmodule

// File: rtl/tso_oe_reg.sv
module tso_oe_reg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic oe_vld_i,
    input  logic data_i,
    output logic oe_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            oe_o <= 1'b0;
        end else if (oe_vld_i) begin
            oe_o <= data_i;
        end
    end

    p_oe_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_vld_i |=> (oe_o == $past(data_i)));

    p_oe_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_vld_i |=> $stable(oe_o));

endmodule

// File: rtl/tso_level_fsm.sv
module tso_level_fsm
    import tso_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int FINE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lvl_vld_i,
    input  logic              data_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic [WORD_W-1:0] word_o
);

    lvl_state_t        state_q;
    lvl_state_t        state_d;
    lvl_trans_t        trans;
    logic [WORD_W-1:0] edge_mask;
    logic [WORD_W-1:0] word_d;

    // Slots at or after the fine position take the new level.
    for (genvar b = 0; b < WORD_W; b++) begin : g_mask
        assign edge_mask[b] = (FINE_W'(b) >= fine_i);
    end

    always_comb begin
        trans = TR_HOLD;
        if (lvl_vld_i) begin
            unique case (state_q)
                ST_LOW:  trans = data_i ? TR_RISE : TR_REPEAT;
                ST_HIGH: trans = data_i ? TR_REPEAT : TR_FALL;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (trans)
            TR_RISE:   state_d = ST_HIGH;
            TR_FALL:   state_d = ST_LOW;
            TR_HOLD:   state_d = state_q;
            TR_REPEAT: state_d = state_q;
        endcase
    end

    always_comb begin
        word_d = {WORD_W{state_q == ST_HIGH}};
        unique case (trans)
            TR_RISE:   word_d = edge_mask;
            TR_FALL:   word_d = ~edge_mask;
            TR_HOLD:   word_d = {WORD_W{state_q == ST_HIGH}};
            TR_REPEAT: word_d = {WORD_W{state_q == ST_HIGH}};
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            word_o <= '0;
        end else begin
            word_o <= word_d;
        end
    end

    p_last_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_vld_i |=> (word_o[WORD_W-1] == $past(data_i)));

    p_first_slot_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_vld_i && fine_i != '0) |=> (word_o[0] == $past(state_q == ST_HIGH)));

    p_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lvl_vld_i |=> (word_o == {WORD_W{word_o[0]}}));

    p_repeat_flat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_vld_i && (data_i == (state_q == ST_HIGH))) |=> (word_o == {WORD_W{word_o[0]}}));

endmodule

// File: rtl/tso_serializer_out.sv
module tso_serializer_out
    import tso_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int FINE_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_i,
    input  logic [1:0]        addr_i,
    input  logic              data_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic [WORD_W-1:0] word_o,
    output logic              oe_o
);

    logic              ev_lvl_vld;
    logic              ev_oe_vld;
    logic              ev_data;
    logic [FINE_W-1:0] ev_fine;

    tso_cmd_stage #(.FINE_W(FINE_W)) u_cmd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stb_i     (stb_i),
        .addr_i    (addr_i),
        .data_i    (data_i),
        .fine_i    (fine_i),
        .lvl_vld_o (ev_lvl_vld),
        .oe_vld_o  (ev_oe_vld),
        .data_o    (ev_data),
        .fine_o    (ev_fine)
    );

    tso_level_fsm #(.WORD_W(WORD_W), .FINE_W(FINE_W)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lvl_vld_i (ev_lvl_vld),
        .data_i    (ev_data),
        .fine_i    (ev_fine),
        .word_o    (word_o)
    );

    tso_oe_reg u_oe (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .oe_vld_i (ev_oe_vld),
        .data_i   (ev_data),
        .oe_o     (oe_o)
    );

    p_level_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_i && addr_i == 2'd0) |=> ##1 (word_o[WORD_W-1] == $past(data_i, 2)));

    p_ignored_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_i && addr_i[1]) |=> ##1 $stable(oe_o));

endmodule

// File: tb/tso_serializer_out_test.sv
module tso_serializer_out_test;

    localparam int W  = 8;
    localparam int FW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic          data = 1'b0;
    logic [FW-1:0] fine = '0;
    logic [W-1:0]  word;
    logic          oe;

    always #4 clk = ~clk;

    tso_serializer_out #(.WORD_W(W)) uut (
        .clk_i (clk), .rst_ni (rst_n), .stb_i (stb), .addr_i (addr),
        .data_i (data), .fine_i (fine), .word_o (word), .oe_o (oe)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // Reference state.
    logic [W-1:0]  exp_word = '0;
    logic          exp_oe = 1'b0;
    logic          lvl = 1'b0;
    logic          p_stb = 1'b0;
    logic [1:0]    p_addr = 2'd0;
    logic          p_data = 1'b0;
    logic [FW-1:0] p_fine = '0;

    function automatic logic [W-1:0] mix(logic old_l, logic new_l, logic [FW-1:0] pos);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) r[b] = (b >= int'(pos)) ? new_l : old_l;
        return r;
    endfunction

    task automatic cmp(string tag);
        compared++;
        if (word !== exp_word) begin
            mismatched++;
            $display("FAIL %s word actual=%b expected=%b", tag, word, exp_word);
        end
        compared++;
        if (oe !== exp_oe) begin
            mismatched++;
            $display("FAIL %s oe actual=%b expected=%b", tag, oe, exp_oe);
        end
    endtask

    // Check the outputs, advance the model one edge, then drive the next command.
    task automatic step(logic s, logic [1:0] a, logic d, logic [FW-1:0] f, string tag);
        @(negedge clk);
        cmp(tag);
        if (p_stb && p_addr == 2'd0) begin
            exp_word = mix(lvl, p_data, p_fine);
            lvl = p_data;
        end else begin
            exp_word = {W{lvl}};
        end
        if (p_stb && p_addr == 2'd1) exp_oe = p_data;
        p_stb = s; p_addr = a; p_data = d; p_fine = f;
        stb = s; addr = a; data = d; fine = f;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 2'd0, 1'b0, 3'd0, "R1");            // reset state
        step(1'b1, 2'd1, 1'b1, 3'd0, "R1");            // enable on
        step(1'b0, 2'd0, 1'b0, 3'd0, "R5");            // not yet visible
        step(1'b0, 2'd0, 1'b0, 3'd0, "R5");            // oe = 1
        step(1'b1, 2'd0, 1'b1, 3'd3, "R5");            // rise at slot 3
        step(1'b0, 2'd0, 1'b0, 3'd0, "R4");            // word still 0x00
        step(1'b0, 2'd0, 1'b0, 3'd0, "R2");            // 0xF8
        step(1'b1, 2'd0, 1'b0, 3'd0, "R3");            // 0xFF; fall at slot 0
        step(1'b0, 2'd0, 1'b0, 3'd0, "R3");
        step(1'b0, 2'd0, 1'b0, 3'd0, "R8");            // 0x00 at once
        step(1'b1, 2'd0, 1'b1, 3'd7, "R3");            // rise at slot 7
        step(1'b0, 2'd0, 1'b0, 3'd0, "R3");
        step(1'b0, 2'd0, 1'b0, 3'd0, "R8");            // 0x80
        step(1'b0, 2'd0, 1'b0, 3'd0, "R3");            // 0xFF
        for (int i = 0; i < 6; i++)
            step(1'b1, 2'd0, 1'b1, 3'd5, "R6");        // strobe held, same data
        step(1'b1, 2'd2, 1'b0, 3'd2, "R6");            // reserved address
        step(1'b1, 2'd3, 1'b0, 3'd0, "R7");            // unused address
        step(1'b1, 2'd2, 1'b0, 3'd6, "R7");
        step(1'b0, 2'd0, 1'b0, 3'd0, "R7");
        step(1'b0, 2'd0, 1'b0, 3'd0, "R7");            // word 0xFF, oe 1 kept
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) != 0, 2'($urandom % 4), 1'($urandom % 2),
                 FW'($urandom % W), "R2");
        end
        step(1'b0, 2'd0, 1'b0, 3'd0, "R3");
        step(1'b0, 2'd0, 1'b0, 3'd0, "R3");
        step(1'b0, 2'd0, 1'b0, 3'd0, "R3");
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule